// File: doc/BRIEF.md
# Byte FIFO with Overflow Gross Error

This block is a sixteen-entry byte queue that sits between a host register port and the bus-side data path of a storage protocol controller. Both the host and the bus sequencer can push bytes into it and pop bytes out of it. Over the same interface the host reads a flags byte. That byte packs the current fill count into its low bits and places a three-bit sequence-step value from the sequencer above the count.

The queue never drops a byte silently on overflow. If a byte is pushed while sixteen bytes are already held, it overwrites the slot at the write position and raises a sticky gross-error flag. Popping while empty is harmless: the output shows the byte at the write position and no state moves. A flush command empties the queue, zeroes the first storage slot and raises a sticky function-complete flag. Both flags stay set until an interrupt acknowledge or a reset. When the sequencer performs a selection, it drains every held byte in order through its pop strobe.

Top module: `byte_fifo_ge`

## Requirements
- R1: After reset the fill count is 0, gross error and function complete are 0, every slot holds 0, and the read data is 0.
- R2: Each push into a non-full queue stores the byte and raises the count by one. Pointers wrap modulo 16, so bytes leave in the order they entered.
- R3: While the count is non-zero, the read data shows the oldest byte. A pop advances to the next byte and lowers the count by one.
- R4: A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged. The same holds for a push and a pop together on a full queue, which sets no gross error.
- R5: A push alone while the count is 16 writes the byte into the slot at the write position, which is also the oldest slot, so the read data then shows the new byte. The count stays 16 and gross error is set.
- R6: A pop while the count is 0 changes no count and no pointer. Meanwhile the read data shows the byte held at the write position.
- R7: A flush sets the count and both pointers to 0, writes 0 into slot 0 and sets function complete. A flush takes priority over any push or pop in the same cycle.
- R8: The flags output equals the sequence-step input in bits 7:5, ORed with the 5-bit fill count in bits 4:0.
- R9: Gross error and function complete are sticky. Only an interrupt acknowledge or reset clears them, a flush does not clear gross error, and a new event in the acknowledge cycle wins over the clear.
- R10: When the host and the sequencer both push in the same cycle, the sequencer's byte is stored and the host's byte is discarded.
- R11: A pop strobe from either the host or the sequencer removes one byte. Both strobes in one cycle still remove only one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host push strobe |
| host_wdata | input | 8 | Host push byte |
| host_rd | input | 1 | Host pop strobe |
| seq_wr | input | 1 | Sequencer push strobe |
| seq_wdata | input | 8 | Sequencer push byte |
| seq_rd | input | 1 | Sequencer pop strobe |
| flush | input | 1 | Empty the queue |
| int_ack | input | 1 | Clear the sticky flags |
| seq_step | input | 3 | Sequence-step value reported in the flags |
| rdata | output | 8 | Byte at the head, or at the write position when empty |
| fill_count | output | 5 | Bytes held, 0 to 16 |
| flags | output | 8 | Step and fill count packed |
| gross_err | output | 1 | Sticky overflow flag |
| func_done | output | 1 | Sticky flush-complete flag |

## Verification
The hardest state to reach from the ports is a full queue whose pointers sit at a non-zero offset. Overwrite and empty-read behaviour only differ from a naive model when the write position is not slot 0. To reach that state, the stimulus first partly fills and drains the queue, then fills it to sixteen and pushes again. A long pseudo-random phase then biases the push strobe high enough to keep crossing the full and empty boundaries. This phase mixes in flushes, acknowledges and collisions between the two push sources.

// File: rtl/byte_fifo_ge.sv
module byte_fifo_ge #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int STEPW = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_wr,
  input  logic [DW-1:0]                 host_wdata,
  input  logic                          host_rd,
  input  logic                          seq_wr,
  input  logic [DW-1:0]                 seq_wdata,
  input  logic                          seq_rd,
  input  logic                          flush,
  input  logic                          int_ack,
  input  logic [STEPW-1:0]              seq_step,
  output logic [DW-1:0]                 rdata,
  output logic [$clog2(DEPTH):0]        fill_count,
  output logic [STEPW+$clog2(DEPTH):0]  flags,
  output logic                          gross_err,
  output logic                          func_done
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  logic          push, pop, empty, full, do_pop, norm_push, over_push;
  logic [DW-1:0] wdata;

  assign push      = host_wr | seq_wr;
  assign wdata     = seq_wr ? seq_wdata : host_wdata;
  assign pop       = host_rd | seq_rd;
  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign do_pop    = pop && !empty;
  assign norm_push = push && (!full || do_pop);
  assign over_push = push && full && !do_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (flush) begin
      mem[0] <= '0;
    end else if (push) begin
      mem[wr_ptr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (norm_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)    rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(norm_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gross_err <= 1'b0;
    else if (over_push && !flush) gross_err <= 1'b1;
    else if (int_ack)            gross_err <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       func_done <= 1'b0;
    else if (flush)   func_done <= 1'b1;
    else if (int_ack) func_done <= 1'b0;
  end

  assign rdata      = empty ? mem[wr_ptr] : mem[rd_ptr];
  assign fill_count = count;
  assign flags      = {seq_step, count};

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH)); // R2
  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full && !flush) |=> (gross_err && fill_count == CW'(DEPTH) && rdata == $past(wdata))); // R5
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty && !flush) |=> (fill_count == '0 && $stable(rdata))); // R6
  AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill_count == '0 && func_done && rdata == '0)); // R7
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty && !flush) |=> $stable(fill_count)); // R4
  AST_GE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (gross_err && !int_ack) |=> gross_err); // R9
endmodule

// File: tb/byte_fifo_ge_tb.sv
module byte_fifo_ge_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, host_wr, host_rd, seq_wr, seq_rd, flush, int_ack;
  logic [7:0] host_wdata, seq_wdata;
  logic [2:0] seq_step;
  logic [7:0] rdata, flags;
  logic [4:0] fill_count;
  logic       gross_err, func_done;

  byte_fifo_ge u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .seq_wr(seq_wr), .seq_wdata(seq_wdata), .seq_rd(seq_rd),
    .flush(flush), .int_ack(int_ack), .seq_step(seq_step), .rdata(rdata),
    .fill_count(fill_count), .flags(flags), .gross_err(gross_err), .func_done(func_done)
  );

  int vectors = 0;
  int errors  = 0;

  logic [7:0] mm [16];
  int wp, rp, cnt;
  bit ge, fc;
  int unsigned lfsr = 32'h1ACE_B00C;

  function automatic int unsigned rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3/R6 rdata", rdata, (cnt == 0) ? mm[wp] : mm[rp]);
    chk("R2 fill_count", fill_count, cnt);
    chk("R8 flags", flags, {seq_step, 5'(cnt)});
    chk("R5/R9 gross_err", gross_err, ge);
    chk("R7/R9 func_done", func_done, fc);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) mm[i] = 8'h00;
    wp = 0; rp = 0; cnt = 0; ge = 0; fc = 0;
  endtask

  task automatic step(bit hw, int hd, bit hr, bit sw, int sd, bit sr, bit fl, bit ack, int st);
    bit push, pop, dp, np, op;
    logic [7:0] d;
    @(negedge clk);
    host_wr = hw; host_wdata = 8'(hd); host_rd = hr;
    seq_wr = sw; seq_wdata = 8'(sd); seq_rd = sr;
    flush = fl; int_ack = ack; seq_step = 3'(st);
    #1 compare_all();
    @(posedge clk);
    push = hw | sw; pop = hr | sr; d = sw ? 8'(sd) : 8'(hd);
    dp = pop && (cnt > 0);
    if (fl) begin
      if (ack) ge = 0;
      cnt = 0; wp = 0; rp = 0; mm[0] = 8'h00; fc = 1;
    end else begin
      np = push && (cnt < 16 || dp);
      op = push && (cnt == 16) && !dp;
      if (push) mm[wp] = d;
      if (ack) begin ge = 0; fc = 0; end
      if (op) ge = 1;
      if (np) wp = (wp + 1) % 16;
      if (dp) rp = (rp + 1) % 16;
      cnt = cnt + int'(np) - int'(dp);
    end
  endtask

  task automatic idle(int st); step(0,0,0,0,0,0,0,0,st); endtask
  task automatic hpush(int d);  step(1,d,0,0,0,0,0,0,2); endtask
  task automatic hpop();        step(0,0,1,0,0,0,0,0,2); endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    host_wr = 0; host_rd = 0; seq_wr = 0; seq_rd = 0; flush = 0; int_ack = 0;
    host_wdata = 0; seq_wdata = 0; seq_step = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: reset state
    idle(5);
    // R2/R3: offset pointers, then fill to 16
    for (int i = 0; i < 5; i++) hpush(8'h10 + i);
    for (int i = 0; i < 5; i++) hpop();
    for (int i = 0; i < 16; i++) hpush(8'h40 + i);
    // R5: overflow write, rdata shows new byte
    hpush(8'hA5);
    idle(1);
    // R9: ack clears gross error
    step(0,0,0,0,0,0,0,1,1);
    // R4: push+pop on full
    step(1,8'h77,1,0,0,0,0,0,3);
    // R11: both pop strobes remove one byte; sequencer drains rest
    step(0,0,1,0,0,1,0,0,4);
    for (int i = 0; i < 15; i++) step(0,0,0,0,0,1,0,0,4);
    // R6: read on empty
    hpop(); hpop();
    // R10: both push sources collide
    step(1,8'h11,0,1,8'h22,0,0,0,6);
    // R4: push+pop on partial queue
    hpush(8'h33);
    step(1,8'h44,1,0,0,0,0,0,6);
    // R9: set gross error, then flush keeps it; R7: flush beats push
    for (int i = 0; i < 16; i++) hpush(8'hC0 + i);
    hpush(8'hEE);
    step(1,8'h99,1,0,0,0,1,0,7);
    idle(7);
    hpop();
    step(0,0,0,0,0,0,0,1,0);
    idle(0);
    // random phase across boundaries
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = rnd();
      step(r[2:0] < 5, int'(r[15:8]), r[5:3] < 3, r[18:16] == 0, int'(r[26:19]),
           r[29:27] == 0, (r % 97) == 0, (r % 31) == 0, int'(r[31:29]));
    end
    idle(0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule